// File: doc/BRIEF.md
# Rotating Byte-Lane Load Aligner

This block turns a 32-bit word, fetched from the aligned word that holds a byte address, into the data a load returns. It rotates the four byte lanes right by the byte offset within the word, so the addressed byte ends up in the lowest lane. It then keeps the low 8, 16 or 32 bits for a byte, halfword or word load and fills the rest with zeros.

A misaligned load never reaches into the following word. Its bytes wrap around inside the one word that was fetched, which is the behaviour of older processors. An alignment check compares the offset with the access size. When fault checking is enabled, a misaligned access returns an abort pulse instead of data. An illegal size code always aborts.

The datapath has one register stage: a request presented with `in_valid` produces its result one clock later.

Top module: `lane_rotate_loader`

## Requirements
- R1: The result is the fetched word rotated right by 8 × `in_addr_lo` bits: output byte k is input byte (k + offset) mod 4. For word 0x12345678, offsets 0, 1, 2 and 3 give 0x12345678, 0x78123456, 0x56781234 and 0x34567812.
- R2: The rotation does not depend on the size. A byte load keeps bits [7:0] of the rotated word and a halfword load keeps bits [15:0]; all bits above the access width are zero. A word load keeps all 32 bits.
- R3: `in_size` encodes 2'b00 as byte, 2'b01 as halfword, 2'b10 as word and 2'b11 as illegal.
- R4: A byte load is aligned at every offset. A halfword load is aligned when `in_addr_lo[0]` is 0. A word load is aligned only when `in_addr_lo` is 2'b00.
- R5: With `fault_en` high, a misaligned access gives `out_fault`=1, `out_valid`=0 and `out_data`=0.
- R6: With `fault_en` low, a misaligned access returns the rotated and truncated data with `out_valid`=1.
- R7: Size code 2'b11 raises `out_fault`, with `out_valid` low and `out_data` zero, whatever the value of `fault_en`.
- R8: Results appear exactly one clock after `in_valid`. A cycle without `in_valid` gives `out_valid`=0, `out_fault`=0 and `out_data`=0 on the next clock.
- R9: `out_valid` and `out_fault` are never high together.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load request is present |
| in_addr_lo | input | 2 | Byte offset of the address within its word |
| in_size | input | 2 | Access size code (R3) |
| in_word | input | 32 | Word read from the aligned word address |
| fault_en | input | 1 | Enables the misalignment abort |
| out_valid | output | 1 | Registered load data is valid |
| out_fault | output | 1 | Registered abort for the request |
| out_data | output | 32 | Rotated, truncated, zero-filled load data |

## Verification
The bench drives every offset with every size, with fault checking on and off, using 0x12345678 and random words. A design that rotated the wrong way would swap the results at offsets 1 and 3. A design that truncated before rotating, or let the size change the rotation, would return wrong halfwords at offset 1. The bench also aims at the halfword at offset 2, which must not fault, and at the illegal size with fault checking off, which must still abort. It checks that upper bits are zero after byte and halfword loads; leftover bits there would expose a design that forgot to mask.

// File: rtl/lrl_pkg.sv
package lrl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } load_size_e;

  // Number of bytes an access of the given size keeps; 0 for the illegal code.
  function automatic int unsigned size_bytes(load_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

  // True when the offset is not a multiple of the access width.
  function automatic logic off_misaligned(load_size_e s, int unsigned off);
    int unsigned nb;
    nb = size_bytes(s);
    if (nb == 0) return 1'b0;
    return (off & (nb - 1)) != 0;
  endfunction
endpackage

// File: rtl/lane_rotator.sv
module lane_rotator #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] rot_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] src;
    assign src = OFF_W'(i) + off_i;   // wraps inside the word
    assign rot_o[i*8 +: 8] = word_i[32'(src)*8 +: 8];
  end
endmodule

// File: rtl/width_masker.sv
module width_masker #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  lrl_pkg::load_size_e size_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   data_o
);
  import lrl_pkg::*;
  int unsigned keep;
  assign keep = size_bytes(size_i);

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign data_o[i*8 +: 8] = (32'(i) < keep) ? data_i[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/align_check.sv
module align_check #(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0]   off_i,
  input  lrl_pkg::load_size_e size_i,
  input  logic               fault_en_i,
  output logic               misaligned_o,
  output logic               illegal_o,
  output logic               fault_o
);
  import lrl_pkg::*;
  assign misaligned_o = off_misaligned(size_i, 32'(off_i));
  assign illegal_o    = (size_i == SZ_BAD);
  assign fault_o      = illegal_o | (fault_en_i & misaligned_o);

  always_comb begin
    if (size_i == SZ_BYTE) begin
      assert_byte_never_misaligned_R4: assert (!misaligned_o);
    end
    if (size_i == SZ_HALF && off_i[0] == 1'b0) begin
      assert_even_half_aligned_R4: assert (!misaligned_o);
    end
  end
endmodule

// File: rtl/lane_rotate_loader.sv
module lane_rotate_loader #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OFF_W-1:0]  in_addr_lo,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_word,
  input  logic              fault_en,
  output logic              out_valid,
  output logic              out_fault,
  output logic [DATA_W-1:0] out_data
);
  import lrl_pkg::*;

  load_size_e        size_e;
  logic [DATA_W-1:0] rot_word;
  logic [DATA_W-1:0] kept_word;
  logic              chk_misaligned, chk_illegal, chk_fault;
  logic              take_data, take_fault;

  assign size_e = load_size_e'(in_size);

  lane_rotator #(.DATA_W(DATA_W)) u_rot (
    .word_i(in_word), .off_i(in_addr_lo), .rot_o(rot_word)
  );

  width_masker #(.DATA_W(DATA_W)) u_mask (
    .size_i(size_e), .data_i(rot_word), .data_o(kept_word)
  );

  align_check #(.OFF_W(OFF_W)) u_chk (
    .off_i(in_addr_lo), .size_i(size_e), .fault_en_i(fault_en),
    .misaligned_o(chk_misaligned), .illegal_o(chk_illegal), .fault_o(chk_fault)
  );

  assign take_fault = in_valid & chk_fault;
  assign take_data  = in_valid & ~chk_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take_data;
      out_fault <= take_fault;
      out_data  <= take_data ? kept_word : '0;
    end
  end

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_fault));

  assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && chk_illegal) |=> (out_fault && !out_valid && out_data == '0));

  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fault_en && chk_misaligned) |=> (out_fault && !out_valid && out_data == '0));

  assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fault_en && !chk_illegal) |=> (out_valid && !out_fault));

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_e == SZ_BYTE) |=> (out_data[DATA_W-1:8] == '0));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_fault && out_data == '0));
endmodule

// File: tb/lane_rotate_loader_tb.sv
module lane_rotate_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_addr_lo = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_word = '0;
  logic        fault_en = 1'b0;
  logic        out_valid, out_fault;
  logic [31:0] out_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_rotate_loader u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr_lo(in_addr_lo),
    .in_size(in_size), .in_word(in_word), .fault_en(fault_en),
    .out_valid(out_valid), .out_fault(out_fault), .out_data(out_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: gather bytes one at a time by arithmetic on integers.
  function automatic logic [31:0] model_data(logic [31:0] w, int off, int sz);
    longint unsigned acc = 0;
    int keep = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < keep; k++) begin
      longint unsigned b = (longint'(w) >> (8 * ((k + off) % 4))) & 255;
      acc = acc + (b << (8 * k));
    end
    return acc[31:0];
  endfunction

  // Drive one cycle at the falling edge; compare at the next falling edge.
  task automatic step(bit v, int off, int sz, logic [31:0] w, bit en, string tag);
    bit ill, mis, flt, ev;
    logic [31:0] ed;
    in_valid = v; in_addr_lo = 2'(off); in_size = 2'(sz); in_word = w; fault_en = en;
    ill = (sz == 3);
    mis = (sz == 1 && (off % 2) != 0) || (sz == 2 && off != 0);
    flt = v && (ill || (en && mis));
    ev  = v && !flt;
    ed  = ev ? model_data(w, off, sz) : 32'h0;
    @(negedge clk);
    check({tag, " valid"}, 32'(out_valid), 32'(ev));
    check({tag, " fault"}, 32'(out_fault), 32'(flt));
    check({tag, " data"},  out_data, ed);
    check("R9 exclusive", 32'(out_valid && out_fault), 32'h0);
  endtask

  function automatic string pick_tag(int off, int sz, bit en);
    if (sz == 3) return "R7";
    if ((sz == 1 && off % 2 != 0) || (sz == 2 && off != 0)) return en ? "R5" : "R6";
    return "R4";
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; in_word = 32'hFFFF_FFFF; in_size = 2'b11;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 32'(out_valid), 32'h0);
    check("R10 reset fault", 32'(out_fault), 32'h0);
    check("R10 reset data",  out_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 fixed rotation values for word loads, fault checks off
    step(1, 0, 2, 32'h12345678, 0, "R1 off0");
    check("R1 off0 literal", out_data, 32'h12345678);
    step(1, 1, 2, 32'h12345678, 0, "R1 off1");
    check("R1 off1 literal", out_data, 32'h78123456);
    step(1, 2, 2, 32'h12345678, 0, "R1 off2");
    check("R1 off2 literal", out_data, 32'h56781234);
    step(1, 3, 2, 32'h12345678, 0, "R1 off3");
    check("R1 off3 literal", out_data, 32'h34567812);

    // R2 truncation after the same rotation; R3 size codes
    step(1, 1, 1, 32'h12345678, 0, "R2 half off1");
    check("R2 half off1 literal", out_data, 32'h00003456);
    step(1, 2, 1, 32'h12345678, 1, "R4 half off2 aligned");
    check("R2 half off2 literal", out_data, 32'h00001234);
    step(1, 3, 0, 32'h12345678, 1, "R4 byte off3");
    check("R3 byte code literal", out_data, 32'h00000012);

    // R5 / R6 / R7 around the enable
    step(1, 1, 2, 32'h12345678, 1, "R5 word off1 abort");
    step(1, 3, 1, 32'hA5A5_5A5A, 1, "R5 half off3 abort");
    step(1, 0, 3, 32'h12345678, 0, "R7 illegal en0");
    step(1, 0, 3, 32'h12345678, 1, "R7 illegal en1");

    // R8 idle cycles and back-to-back requests
    step(0, 2, 2, 32'hDEADBEEF, 1, "R8 idle");
    step(1, 2, 0, 32'hDEADBEEF, 1, "R8 after idle");
    step(0, 0, 3, 32'h0, 0, "R8 idle bad size");

    // Exhaustive sweep over offset, size and enable
    for (int en = 0; en < 2; en++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          step(1, off, sz, 32'hC3D2E1F0, bit'(en), pick_tag(off, sz, bit'(en)));

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      int off = int'($urandom_range(3));
      int sz  = int'($urandom_range(3));
      bit en  = bit'($urandom_range(1));
      bit v   = ($urandom_range(4) != 0);
      step(v, off, sz, $urandom, en, v ? pick_tag(off, sz, en) : "R8");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule